// File: doc/BRIEF.md
# NAND Flash Byte-Bus Sequencer with Programmable Timing

This block sits between a simple word-wide register port and an 8-bit NAND flash bus. Software writes a command byte, an address byte or a data byte into the matching register, or reads the data register. Each such access becomes exactly one bus cycle on the flash pins. A cycle runs in three parts: the signals settle, then the strobe is active, then the signals are held. The length of each part comes from a timing register. Reads and writes use separate timing sets.

When a cycle finishes, the engine waits a programmable ready-wait count before it looks at the synchronized ready/busy pin. This keeps it from missing a busy indication that the flash raises late. It then stays busy until the flash reports ready. While a cycle is open, the host sees `host_busy` high. Every host access except a control-register write is dropped during that time. The host therefore polls `host_busy` before each access.

The block also holds these registers:
- a status register that mirrors the ready pin;
- an interrupt status register with two events, plus an enable register and a write-one-to-clear register;
- a configuration bit that holds chip enable low permanently;
- a control bit that soft-resets the engine.

Register word indices: 0 data, 1 address, 2 command, 3 control, 4 configuration, 5 status, 6 interrupt status, 7 interrupt enable, 8 interrupt clear, 9 timing.

Top module: `nand_bus_engine`

## Requirements
- R1: The timing register (index 9) is a 32-bit register of 4-bit fields and reads back as written. The fields are: [31:28] write ready-wait, [27:24] write strobe width, [23:20] write hold, [19:16] write setup, [15:12] read ready-wait, [11:8] read strobe width, [7:4] read hold, [3:0] read setup. It resets to 0.
- R2: Each bus cycle spends max(field,1) clocks in setup, then max(field,1) clocks with the strobe low, then max(field,1) clocks in hold. The fields come from the read set for data reads and from the write set for all other cycles.
- R3: A write to the command register (index 2) gives one cycle with `nand_cle` high from setup through hold and one `nand_we_n` strobe. `nand_dq_out` carries only bits [7:0] of the written word.
- R4: A write to the address register (index 1) gives one cycle with `nand_ale` high from setup through hold and one `nand_we_n` strobe. Only bits [7:0] are carried.
- R5: A write to the data register (index 0) gives one `nand_we_n` strobe with both latch enables low. `nand_dq_oe` is high from setup through hold.
- R6: A read of the data register starts a cycle with a `nand_re_n` strobe and no output enable. The flash byte is sampled in the last strobe clock. It appears zero-extended on `host_rdata` once `host_busy` falls. Other register reads update `host_rdata` one clock after acceptance.
- R7: After hold, the engine stays busy for max(ready-wait,1) clocks. It then stays busy until the synchronized ready pin is high. The cycle adds one further busy clock once the pin is seen ready.
- R8: When configuration bit 5 is 1, `nand_ce_n` is low at all times. When it is 0, `nand_ce_n` is low only from setup through hold. The bit reads back at bit 5.
- R9: Status bit 0 shows the ready pin (1 = ready) after a synchronizer of `SYNC_STAGES` flops.
- R10: Interrupt status bit 0 is set on a rising edge of the synchronized ready pin. Bit 1 is set when a bus cycle completes. Writing 1 to a bit in the clear register (index 8) clears that status bit. `irq` is the OR of the status bits masked by the enable register (index 7).
- R11: While `host_busy` is high, any access other than a control-register write is ignored.
- R12: Writing control bit 2 (index 3) at any time aborts a cycle in progress. All strobes and latch enables are released, `host_busy` drops on the next clock, and interrupt status is cleared.
- R13: After reset: `nand_ce_n`, `nand_we_n` and `nand_re_n` are high; `nand_cle`, `nand_ale`, `host_busy` and `irq` are low; timing, enable and status registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register word index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| host_busy | output | 1 | Bus cycle in progress; accesses other than control writes are dropped |
| irq | output | 1 | Masked interrupt |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Byte driven to flash |
| nand_dq_oe | output | 1 | Output enable for the byte bus |
| nand_dq_in | input | 8 | Byte from flash |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench builds the block with its defaults: a two-flop ready synchronizer and 4-bit timing fields. This lets it predict the exact busy length of each cycle as setup + strobe + hold + ready-wait + 1.

First it runs cycles at the all-zero reset timing, which checks the one-clock minimum of every phase. Then it loads distinct read and write timing sets, so a mix-up between the two sets, or between any two fields, changes a counted duration. Holding the ready pin low stretches the final wait. That makes room to test both the stall rule and the soft-reset abort in the middle of a cycle.

// File: rtl/nandif_pkg.sv
package nandif_pkg;
    localparam int HOST_W = 32;
    localparam int NAND_W = 8;
    localparam int TFLD_W = 4;
    localparam int RIDX_W = 4;

    localparam int CFG_CE_BIT  = 5;
    localparam int CTRL_RST_BIT = 2;
    localparam int NUM_EVT     = 2;

    typedef enum logic [RIDX_W-1:0] {
        RI_DATA  = 4'd0,
        RI_ADDR  = 4'd1,
        RI_CMD   = 4'd2,
        RI_CTRL  = 4'd3,
        RI_CFG   = 4'd4,
        RI_STAT  = 4'd5,
        RI_ISTAT = 4'd6,
        RI_IEN   = 4'd7,
        RI_ICLR  = 4'd8,
        RI_TIME  = 4'd9
    } ridx_e;

    typedef enum logic [1:0] {OP_CMD, OP_ADR, OP_WR, OP_RD} op_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_RWAIT, PH_BWAIT
    } phase_e;

    typedef struct packed {
        logic [TFLD_W-1:0] w_rdy;
        logic [TFLD_W-1:0] w_width;
        logic [TFLD_W-1:0] w_hold;
        logic [TFLD_W-1:0] w_setup;
        logic [TFLD_W-1:0] r_rdy;
        logic [TFLD_W-1:0] r_width;
        logic [TFLD_W-1:0] r_hold;
        logic [TFLD_W-1:0] r_setup;
    } timing_t;
endpackage

// File: rtl/nandif_rb_sync.sv
module nandif_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t s_d, s_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb s_d.sh = async_in;
        end else begin : g_chain
            always_comb s_d.sh = {s_q.sh[STAGES-2:0], async_in};
        end
    endgenerate

    always_comb s_d.prev = s_q.sh[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign sync_out = s_q.sh[STAGES-1];
    assign rise     = s_q.sh[STAGES-1] & ~s_q.prev;
endmodule

// File: rtl/nandif_phase_seq.sv
module nandif_phase_seq
    import nandif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  op_e               op,
    input  logic [NAND_W-1:0] byte_in,
    input  timing_t           tim,
    input  logic              rdy,
    input  logic [NAND_W-1:0] dq_in,
    output logic              busy,
    output logic              active,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [NAND_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              cap_valid,
    output logic [NAND_W-1:0] cap_byte,
    output logic              done
);
    typedef struct packed {
        phase_e            ph;
        op_e               op;
        logic [TFLD_W-1:0] cnt;
        logic [NAND_W-1:0] dat;
    } seq_t;

    seq_t s_d, s_q;

    function automatic logic [TFLD_W-1:0] ld(input logic [TFLD_W-1:0] f);
        return (f == '0) ? '0 : f - 1'b1;
    endfunction

    logic is_rd, last;
    assign is_rd = (s_q.op == OP_RD);
    assign last  = (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: if (start) begin
                s_d.ph  = PH_SETUP;
                s_d.op  = op;
                s_d.dat = byte_in;
                s_d.cnt = ld((op == OP_RD) ? tim.r_setup : tim.w_setup);
            end
            PH_SETUP: begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (last) begin
                    s_d.ph  = PH_STROBE;
                    s_d.cnt = ld(is_rd ? tim.r_width : tim.w_width);
                end
            end
            PH_STROBE: begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (last) begin
                    s_d.ph  = PH_HOLD;
                    s_d.cnt = ld(is_rd ? tim.r_hold : tim.w_hold);
                    if (is_rd) s_d.dat = dq_in;
                end
            end
            PH_HOLD: begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (last) begin
                    s_d.ph  = PH_RWAIT;
                    s_d.cnt = ld(is_rd ? tim.r_rdy : tim.w_rdy);
                end
            end
            PH_RWAIT: begin
                s_d.cnt = s_q.cnt - 1'b1;
                if (last) s_d.ph = PH_BWAIT;
            end
            PH_BWAIT: if (rdy) s_d.ph = PH_IDLE;
            default:  s_d.ph = PH_IDLE;
        endcase
        if (abort) begin
            s_d.ph  = PH_IDLE;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE, op: OP_CMD, cnt: '0, dat: '0};
        else        s_q <= s_d;
    end

    assign busy      = (s_q.ph != PH_IDLE);
    assign active    = (s_q.ph == PH_SETUP) || (s_q.ph == PH_STROBE) || (s_q.ph == PH_HOLD);
    assign cle       = active && (s_q.op == OP_CMD);
    assign ale       = active && (s_q.op == OP_ADR);
    assign we_n      = !((s_q.ph == PH_STROBE) && !is_rd);
    assign re_n      = !((s_q.ph == PH_STROBE) && is_rd);
    assign dq_out    = s_q.dat;
    assign dq_oe     = active && !is_rd;
    assign cap_valid = (s_q.ph == PH_STROBE) && last && is_rd && !abort;
    assign cap_byte  = dq_in;
    assign done      = (s_q.ph == PH_BWAIT) && rdy && !abort;
endmodule

// File: rtl/nandif_regs.sv
module nandif_regs
    import nandif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [RIDX_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    input  logic              seq_busy,
    input  logic              cap_valid,
    input  logic [NAND_W-1:0] cap_byte,
    input  logic              done,
    input  logic              rdy,
    input  logic              rdy_rise,
    output logic [HOST_W-1:0] host_rdata,
    output logic              start,
    output op_e               op,
    output logic [NAND_W-1:0] byte_out,
    output timing_t           tim,
    output logic              ce_force,
    output logic              soft_rst,
    output logic              irq
);
    typedef struct packed {
        logic               ce_force;
        logic [NUM_EVT-1:0] ien;
        logic [NUM_EVT-1:0] ist;
        timing_t            tim;
        logic [HOST_W-1:0]  rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic ctrl_wr, accept, wr, rd;

    assign ctrl_wr  = host_sel && host_we && (host_addr == RI_CTRL);
    assign soft_rst = ctrl_wr && host_wdata[CTRL_RST_BIT];
    assign accept   = host_sel && (!seq_busy || ctrl_wr);
    assign wr       = accept && host_we;
    assign rd       = accept && !host_we;

    assign start = !soft_rst &&
        ((wr && (host_addr == RI_CMD || host_addr == RI_ADDR || host_addr == RI_DATA)) ||
         (rd && host_addr == RI_DATA));
    assign op = (host_addr == RI_CMD)  ? OP_CMD :
                (host_addr == RI_ADDR) ? OP_ADR :
                host_we                ? OP_WR  : OP_RD;
    assign byte_out = host_wdata[NAND_W-1:0];

    always_comb begin
        r_d = r_q;
        if (wr) begin
            unique case (host_addr)
                RI_CFG:  r_d.ce_force = host_wdata[CFG_CE_BIT];
                RI_IEN:  r_d.ien      = host_wdata[NUM_EVT-1:0];
                RI_TIME: r_d.tim      = timing_t'(host_wdata);
                RI_ICLR: r_d.ist      = r_q.ist & ~host_wdata[NUM_EVT-1:0];
                default: ;
            endcase
        end
        r_d.ist = r_d.ist | {done, rdy_rise};
        if (soft_rst) r_d.ist = '0;
        if (rd) begin
            unique case (host_addr)
                RI_STAT:  r_d.rdata = HOST_W'(rdy);
                RI_CFG:   r_d.rdata = HOST_W'(r_q.ce_force) << CFG_CE_BIT;
                RI_ISTAT: r_d.rdata = HOST_W'(r_q.ist);
                RI_IEN:   r_d.rdata = HOST_W'(r_q.ien);
                RI_TIME:  r_d.rdata = HOST_W'(r_q.tim);
                default:  r_d.rdata = r_q.rdata;
            endcase
        end
        if (cap_valid) r_d.rdata = HOST_W'(cap_byte);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign host_rdata = r_q.rdata;
    assign tim        = r_q.tim;
    assign ce_force   = r_q.ce_force;
    assign irq        = |(r_q.ist & r_q.ien);
endmodule

// File: rtl/nand_bus_engine.sv
module nand_bus_engine
    import nandif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [RIDX_W-1:0] host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              host_busy,
    output logic              irq,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [NAND_W-1:0] nand_dq_out,
    output logic              nand_dq_oe,
    input  logic [NAND_W-1:0] nand_dq_in,
    input  logic              nand_rb
);
    logic              rdy, rdy_rise, start, ce_force, soft_rst;
    logic              seq_busy, active, cap_valid, done;
    logic [NAND_W-1:0] byte_out, cap_byte;
    op_e               op;
    timing_t           tim;

    nandif_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nand_rb),
        .sync_out(rdy), .rise(rdy_rise)
    );

    nandif_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .seq_busy(seq_busy),
        .cap_valid(cap_valid), .cap_byte(cap_byte), .done(done),
        .rdy(rdy), .rdy_rise(rdy_rise), .host_rdata(host_rdata),
        .start(start), .op(op), .byte_out(byte_out), .tim(tim),
        .ce_force(ce_force), .soft_rst(soft_rst), .irq(irq)
    );

    nandif_phase_seq u_seq (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .start(start),
        .op(op), .byte_in(byte_out), .tim(tim), .rdy(rdy),
        .dq_in(nand_dq_in), .busy(seq_busy), .active(active),
        .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n), .re_n(nand_re_n),
        .dq_out(nand_dq_out), .dq_oe(nand_dq_oe),
        .cap_valid(cap_valid), .cap_byte(cap_byte), .done(done)
    );

    assign host_busy = seq_busy;
    assign nand_ce_n = !(ce_force || active);
endmodule

// File: rtl/nand_bus_engine_chk.sv
module nand_bus_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic host_busy,
    input logic nand_ce_n,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_we_n,
    input logic nand_re_n,
    input logic nand_dq_oe,
    input logic ce_force
);
    // R2: never a read and a write strobe together
    a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R3 / R4: latch enables are exclusive and occur only with chip enable
    a_r3_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    a_r4_latch_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> !nand_ce_n);
    // R5: a write strobe always has the bus driven and the host stalled
    a_r5_we_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_dq_oe && host_busy && !nand_ce_n));
    // R6: a read strobe never has the bus driven
    a_r6_re_float: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);
    // R8: forced chip enable holds it low
    a_r8_ce_forced: assert property (@(posedge clk) disable iff (!rst_n)
        ce_force |-> !nand_ce_n);
    // R11: outside a cycle no pin activity
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !host_busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale));
endmodule

bind nand_bus_engine nand_bus_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .host_busy(host_busy), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe), .ce_force(ce_force)
);

// File: tb/nand_bus_engine_test.sv
module nand_bus_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_busy, irq;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'hA5;
    logic        nand_rb = 1'b1;

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;
    int n_busy, n_we, n_re, n_cle, n_ale, n_oe, n_ce;
    logic [7:0] seen_dq;

    always #2 clk = ~clk;

    nand_bus_engine uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic acc(input logic [3:0] a, input logic we, input logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic idle_wait();
        while (host_busy) @(negedge clk);
    endtask

    task automatic put(input logic [3:0] a, input logic [31:0] d);
        idle_wait(); acc(a, 1'b1, d);
    endtask

    task automatic get(input logic [3:0] a, output logic [31:0] d);
        idle_wait(); acc(a, 1'b0, 0); d = host_rdata;
    endtask

    task automatic watch();
        n_busy = 0; n_we = 0; n_re = 0; n_cle = 0; n_ale = 0; n_oe = 0; n_ce = 0;
        for (int i = 0; i < 300 && host_busy; i++) begin
            n_busy++;
            if (!nand_we_n) begin n_we++; seen_dq = nand_dq_out; end
            if (!nand_re_n) n_re++;
            if (nand_cle) n_cle++;
            if (nand_ale) n_ale++;
            if (nand_dq_oe) n_oe++;
            if (!nand_ce_n) n_ce++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R13 ce_n", nand_ce_n, 1); check("R13 we_n", nand_we_n, 1);
        check("R13 re_n", nand_re_n, 1); check("R13 cle", nand_cle, 0);
        check("R13 ale", nand_ale, 0); check("R13 busy", host_busy, 0);
        check("R13 irq", irq, 0);
        get(4'd9, v); check("R13 timing", v, 0);
        get(4'd6, v); check("R13 istat", v, 0);
    endtask

    task automatic t_cmd_default();
        acc(4'd2, 1'b1, 32'hFFFF_FF3C); watch();
        check("R2 busy min", n_busy, 5); check("R3 cle", n_cle, 3);
        check("R3 we", n_we, 1); check("R3 byte", seen_dq, 8'h3C);
        check("R3 ale", n_ale, 0); check("R8 ce", n_ce, 3);
    endtask

    task automatic t_timing();
        logic [31:0] v;
        put(4'd9, 32'h4312_2531); get(4'd9, v);
        check("R1 readback", v, 32'h4312_2531);
    endtask

    task automatic t_addr();
        acc(4'd1, 1'b1, 32'h0000_01C7); watch();
        check("R2 write busy", n_busy, 11); check("R4 ale", n_ale, 6);
        check("R4 we", n_we, 3); check("R4 byte", seen_dq, 8'hC7);
        check("R4 cle", n_cle, 0);
    endtask

    task automatic t_wdata();
        acc(4'd0, 1'b1, 32'h0000_005A); watch();
        check("R5 busy", n_busy, 11); check("R5 latch", n_cle + n_ale, 0);
        check("R5 oe", n_oe, 6); check("R5 byte", seen_dq, 8'h5A);
    endtask

    task automatic t_rdata();
        nand_dq_in = 8'hA5;
        acc(4'd0, 1'b0, 0); watch();
        check("R2 read busy", n_busy, 12); check("R6 re", n_re, 5);
        check("R6 we", n_we, 0); check("R6 oe", n_oe, 0);
        check("R6 rdata", host_rdata, 32'h0000_00A5);
    endtask

    task automatic t_ce();
        logic [31:0] v;
        put(4'd4, 32'h20); @(negedge clk);
        check("R8 forced", nand_ce_n, 0);
        get(4'd4, v); check("R8 cfg read", v, 32'h20);
        put(4'd4, 0); @(negedge clk);
        check("R8 released", nand_ce_n, 1);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        get(4'd6, v); check("R10 done event", v, 2);
        check("R10 masked", irq, 0);
        put(4'd7, 2); @(negedge clk); check("R10 enabled", irq, 1);
        put(4'd8, 2); @(negedge clk); check("R10 cleared irq", irq, 0);
        get(4'd6, v); check("R10 cleared", v, 0);
    endtask

    task automatic t_stall();
        logic [31:0] v;
        acc(4'd0, 1'b0, 0);
        acc(4'd4, 1'b1, 32'h20);
        watch();
        get(4'd4, v); check("R11 ignored", v, 0);
        check("R11 ce idle", nand_ce_n, 1);
    endtask

    task automatic t_ready();
        logic [31:0] v;
        bit high_at_40 = 0;
        put(4'd8, 3);
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        get(4'd5, v); check("R9 busy pin", v, 0);
        acc(4'd2, 1'b1, 32'h70);
        for (int i = 0; i < 40; i++) @(negedge clk);
        high_at_40 = host_busy;
        check("R7 waits ready", high_at_40, 1);
        nand_rb = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 released", host_busy, 0);
        get(4'd5, v); check("R9 ready pin", v, 1);
        get(4'd6, v); check("R10 ready event", v[0], 1);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        nand_rb = 1'b0;
        repeat (4) @(negedge clk);
        acc(4'd0, 1'b1, 32'h11);
        repeat (30) @(negedge clk);
        check("R12 hung", host_busy, 1);
        acc(4'd3, 1'b1, 32'h4);
        check("R12 busy drop", host_busy, 0);
        check("R12 pins", {nand_we_n, nand_re_n, nand_cle, nand_ale, nand_ce_n}, 5'b11001);
        get(4'd6, v); check("R12 istat", v, 0);
        nand_rb = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cmd_default();
        t_timing();
        t_addr();
        t_wdata();
        t_rdata();
        t_ce();
        t_irq();
        t_stall();
        t_ready();
        t_soft_reset();
        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule